// File: doc/BRIEF.md
# Indirect Voice Register File Host Interface

This block lets a host reach a bank of per-voice 16-bit registers through four narrow ports. The host first writes a voice number into a voice pointer port and an operation code into a function pointer port. It then moves data through a data port. That port can be accessed as one 16-bit word or as two separate byte lanes. The block forms the storage address from the two pointers. Byte writes go through per-lane write enables and touch only their own half of the word. Reads come back one cycle later, either as a whole word or as one lane placed in the low byte.

Reads and writes of the same voice register use different operation codes: the read code is the write code with bit 7 set. Two other codes are handled here. One holds an active-voice count. The other holds a run bit, and voice writes are dropped while that bit is low. The host bus is plain: strobes are one cycle wide and the block accepts every access in the cycle it is presented, so there is no back-pressure. The read result appears with a one-cycle valid pulse that cannot be stalled. A read strobe and a write strobe are never presented in the same cycle.

Top module: `vrf_host_if`

## Requirements
- R1: Port 0 holds an 8-bit voice pointer. A read of port 0 returns {8'h00, pointer}. Only pointer bits 4:0 pick the voice, so 0x23 and 0xE3 both address voice 3.
- R2: Port 1 holds an 8-bit function pointer. A read of port 1 returns {8'h00, pointer}. Pointer bits 3:0 pick the word within the voice.
- R3: The storage word for a voice access is voice*16 + function. Each of the 32 voices has 16 words, and a write to one voice/word leaves every other voice/word unchanged.
- R4: When port 2 or port 3 is read with the word size, the result is the whole word. A byte read of port 2 returns {8'h00, word[7:0]}, and a byte read of port 3 returns {8'h00, word[15:8]}.
- R5: A data-port write with function 0x0E loads the active-voice count from wdata[7:0]. A data-port read with function 0x8E returns {8'h00, count} for either port and size. The count is 0xCD after reset, and it returns to 0xCD whenever a 0x4C write clears bit 0.
- R6: A data-port write with function 0x4C loads the run bit from wdata[0]. The run bit is 0 after reset. Voice register writes have no effect while the run bit is 0.
- R7: A byte write to port 2 replaces word[7:0] with wdata[7:0]. A byte write to port 3 replaces word[15:8] with wdata[7:0]. A word write at either data port replaces all 16 bits.
- R8: Voice words are written with function codes 0x00–0x0D and read with 0x80–0x8D. A data-port read with any other code except 0x8E returns 0xFFFF for either size. A data-port write with any other code except 0x0E and 0x4C has no effect.
- R9: host_rvalid is high exactly in the cycle after a cycle with host_rd, and low after reset. host_rdata holds the result while host_rvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe |
| host_port | input | 2 | 0 voice pointer, 1 function pointer, 2 data low lane, 3 data high lane |
| host_word | input | 1 | 1 selects a 16-bit access, 0 a byte access |
| host_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| host_rdata | output | 16 | Read result, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read result valid, one cycle after host_rd |

## Verification
The bench builds the block with its default parameters: a 5-bit voice index, a 4-bit function index, a last voice function of 13 and a count reset value of 0xCD. These values make the whole 512-word space addressable, so the bench can reach voice 31 at function 13 and the pointer bits above bit 4 that must be ignored. They also place the unused codes 0x0F and 0x8F right next to the valid ranges, so both can be tested. After a mid-run reset, the bench checks that the storage contents survive while the run bit and the count return to their reset values.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;
  localparam int SEL_W  = 8;

  typedef enum logic [1:0] {
    PORT_VPTR = 2'd0,
    PORT_FPTR = 2'd1,
    PORT_DLO  = 2'd2,
    PORT_DHI  = 2'd3
  } port_e;

  typedef enum logic [2:0] {
    SRC_VPTR,
    SRC_FPTR,
    SRC_VOICE,
    SRC_COUNT,
    SRC_ONES
  } rd_src_e;

  localparam logic [SEL_W-1:0] FN_COUNT_WR = 8'h0E;
  localparam logic [SEL_W-1:0] FN_COUNT_RD = 8'h8E;
  localparam logic [SEL_W-1:0] FN_RUN_WR   = 8'h4C;
endpackage

// File: rtl/vrf_access_decode.sv
module vrf_access_decode
  import vrf_pkg::*;
#(
  parameter int FUNC_W  = 4,
  parameter int LAST_FN = 13
) (
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_port,
  input  logic              host_word,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [SEL_W-1:0]  fptr_q,
  input  logic              run_q,
  output logic              vptr_we,
  output logic              fptr_we,
  output logic              run_we,
  output logic              cnt_we,
  output logic [LANES-1:0]  ram_be,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_re,
  output rd_src_e           rd_src,
  output logic              rd_hi,
  output logic              rd_byte
);
  port_e              port;
  logic               data_port;
  logic [FUNC_W-1:0]  fn_idx;
  logic               fn_in_range;
  logic               upper_clear;
  logic               voice_wr_code;
  logic               voice_rd_code;

  assign port          = port_e'(host_port);
  assign data_port     = (port == PORT_DLO) || (port == PORT_DHI);
  assign fn_idx        = fptr_q[FUNC_W-1:0];
  assign fn_in_range   = (int'(fn_idx) <= LAST_FN);
  assign upper_clear   = (fptr_q[SEL_W-2:FUNC_W] == '0);
  assign voice_wr_code = !fptr_q[SEL_W-1] && upper_clear && fn_in_range;
  assign voice_rd_code =  fptr_q[SEL_W-1] && upper_clear && fn_in_range;

  assign vptr_we = host_wr && (port == PORT_VPTR);
  assign fptr_we = host_wr && (port == PORT_FPTR);
  assign run_we  = host_wr && data_port && (fptr_q == FN_RUN_WR);
  assign cnt_we  = host_wr && data_port && (fptr_q == FN_COUNT_WR);

  always_comb begin
    ram_be = '0;
    if (host_wr && data_port && voice_wr_code && run_q) begin
      if (host_word)               ram_be = '1;
      else if (port == PORT_DHI)   ram_be = 2'b10;
      else                         ram_be = 2'b01;
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_wlane
      assign ram_wdata[l*8 +: 8] = host_word ? host_wdata[l*8 +: 8] : host_wdata[7:0];
    end
  endgenerate

  assign ram_re  = host_rd && data_port && voice_rd_code;
  assign rd_hi   = (port == PORT_DHI);
  assign rd_byte = !host_word;

  always_comb begin
    case (port)
      PORT_VPTR: rd_src = SRC_VPTR;
      PORT_FPTR: rd_src = SRC_FPTR;
      default: begin
        if (voice_rd_code)               rd_src = SRC_VOICE;
        else if (fptr_q == FN_COUNT_RD)  rd_src = SRC_COUNT;
        else                             rd_src = SRC_ONES;
      end
    endcase
  end
endmodule

// File: rtl/vrf_sel_regs.sv
module vrf_sel_regs
  import vrf_pkg::*;
#(
  parameter logic [SEL_W-1:0] COUNT_INIT = 8'hCD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vptr_we,
  input  logic             fptr_we,
  input  logic             run_we,
  input  logic             cnt_we,
  input  logic [SEL_W-1:0] wbyte,
  output logic [SEL_W-1:0] vptr_q,
  output logic [SEL_W-1:0] fptr_q,
  output logic             run_q,
  output logic [SEL_W-1:0] count_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vptr_q  <= '0;
      fptr_q  <= '0;
      run_q   <= 1'b0;
      count_q <= COUNT_INIT;
    end else begin
      if (vptr_we) vptr_q <= wbyte;
      if (fptr_we) fptr_q <= wbyte;
      if (run_we)  run_q  <= wbyte[0];
      if (run_we && !wbyte[0]) count_q <= COUNT_INIT;
      else if (cnt_we)         count_q <= wbyte;
    end
  end
endmodule

// File: rtl/vrf_word_ram.sv
module vrf_word_ram
  import vrf_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] mem [DEPTH];
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (be[l]) mem[addr] <= wdata[l*8 +: 8];
        if (re)    q <= mem[addr];
      end
      assign rdata[l*8 +: 8] = q;
    end
  endgenerate
endmodule

// File: rtl/vrf_read_path.sv
module vrf_read_path
  import vrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  rd_src_e           rd_src,
  input  logic              rd_hi,
  input  logic              rd_byte,
  input  logic [SEL_W-1:0]  vptr_q,
  input  logic [SEL_W-1:0]  fptr_q,
  input  logic [SEL_W-1:0]  count_q,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid
);
  rd_src_e          src_q;
  logic             hi_q;
  logic             byte_q;
  logic [SEL_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      src_q       <= SRC_ONES;
      hi_q        <= 1'b0;
      byte_q      <= 1'b0;
      snap_q      <= '0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) begin
        src_q  <= rd_src;
        hi_q   <= rd_hi;
        byte_q <= rd_byte;
        case (rd_src)
          SRC_VPTR:  snap_q <= vptr_q;
          SRC_FPTR:  snap_q <= fptr_q;
          SRC_COUNT: snap_q <= count_q;
          default:   snap_q <= '0;
        endcase
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_VOICE: begin
        if (!byte_q)   host_rdata = ram_q;
        else if (hi_q) host_rdata = {8'h00, ram_q[15:8]};
        else           host_rdata = {8'h00, ram_q[7:0]};
      end
      SRC_ONES: host_rdata = '1;
      default:  host_rdata = {8'h00, snap_q};
    endcase
  end
endmodule

// File: rtl/vrf_host_if.sv
module vrf_host_if
  import vrf_pkg::*;
#(
  parameter int               VOICE_W    = 5,
  parameter int               FUNC_W     = 4,
  parameter int               LAST_FN    = 13,
  parameter logic [SEL_W-1:0] COUNT_INIT = 8'hCD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_port,
  input  logic        host_word,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        host_rvalid
);
  localparam int ADDR_W = VOICE_W + FUNC_W;

  logic              vptr_we, fptr_we, run_we, cnt_we;
  logic [LANES-1:0]  ram_be;
  logic [DATA_W-1:0] ram_wdata, ram_q;
  logic              ram_re;
  rd_src_e           rd_src;
  logic              rd_hi, rd_byte;
  logic [SEL_W-1:0]  vptr_q, fptr_q, count_q;
  logic              run_q;
  logic [ADDR_W-1:0] ram_addr;

  vrf_access_decode #(.FUNC_W(FUNC_W), .LAST_FN(LAST_FN)) u_decode (
    .host_wr(host_wr), .host_rd(host_rd), .host_port(host_port),
    .host_word(host_word), .host_wdata(host_wdata),
    .fptr_q(fptr_q), .run_q(run_q),
    .vptr_we(vptr_we), .fptr_we(fptr_we), .run_we(run_we), .cnt_we(cnt_we),
    .ram_be(ram_be), .ram_wdata(ram_wdata), .ram_re(ram_re),
    .rd_src(rd_src), .rd_hi(rd_hi), .rd_byte(rd_byte)
  );

  vrf_sel_regs #(.COUNT_INIT(COUNT_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .vptr_we(vptr_we), .fptr_we(fptr_we), .run_we(run_we), .cnt_we(cnt_we),
    .wbyte(host_wdata[7:0]),
    .vptr_q(vptr_q), .fptr_q(fptr_q), .run_q(run_q), .count_q(count_q)
  );

  // voice in the upper address bits, function index in the lower ones
  assign ram_addr = {vptr_q[VOICE_W-1:0], fptr_q[FUNC_W-1:0]};

  vrf_word_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .addr(ram_addr), .be(ram_be), .wdata(ram_wdata),
    .re(ram_re), .rdata(ram_q)
  );

  vrf_read_path u_rd (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd),
    .rd_src(rd_src), .rd_hi(rd_hi), .rd_byte(rd_byte),
    .vptr_q(vptr_q), .fptr_q(fptr_q), .count_q(count_q),
    .ram_q(ram_q), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  logic data_acc;
  logic rd_code_set;
  assign data_acc    = (host_port == 2'd2) || (host_port == 2'd3);
  assign rd_code_set = fptr_q[7] && (fptr_q[6:FUNC_W] == '0) &&
                       (int'(fptr_q[FUNC_W-1:0]) <= LAST_FN);

  a_r9_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);
  a_r9_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);
  a_r8_unknown_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && data_acc && !rd_code_set && fptr_q != FN_COUNT_RD) |=> (host_rdata == 16'hFFFF));
  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && data_acc && !host_word && rd_code_set) |=> (host_rdata[15:8] == 8'h00));
  a_r5_count_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && data_acc && fptr_q == FN_RUN_WR && !host_wdata[0]) |=> (count_q == COUNT_INIT));
  a_r6_halted_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_be != '0) |-> run_q);
  a_r7_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !host_word |-> (ram_be != 2'b11));
endmodule

// File: tb/vrf_host_if_bench.sv
module vrf_host_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_port = 2'd0;
  logic        host_word = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        host_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vrf_host_if u_vrf_host_if (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_port(host_port), .host_word(host_word), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  localparam logic [1:0] P_VP = 2'd0, P_FP = 2'd1, P_LO = 2'd2, P_HI = 2'd3;

  // entry: {req[3:0], is_read, port[1:0], word, wdata[15:0], expected[15:0]}
  function automatic logic [39:0] vw(logic [1:0] p, logic w, logic [15:0] d);
    return {4'd0, 1'b0, p, w, d, 16'h0000};
  endfunction
  function automatic logic [39:0] vr(logic [3:0] r, logic [1:0] p, logic w, logic [15:0] e);
    return {r, 1'b1, p, w, 16'h0000, e};
  endfunction

  localparam int NV = 55;
  localparam logic [39:0] VEC [NV] = '{
    vr(8, P_LO, 1, 16'hFFFF),            // R8 code 0x00 read
    vw(P_FP, 0, 16'h008E),
    vr(5, P_LO, 1, 16'h00CD),            // R5 reset count
    vr(2, P_FP, 0, 16'h008E),            // R2
    vw(P_FP, 0, 16'h004C),
    vw(P_LO, 1, 16'h0001),               // R6 run on
    vw(P_VP, 0, 16'h00E3),
    vr(1, P_VP, 0, 16'h00E3),            // R1
    vw(P_FP, 0, 16'h0002),
    vw(P_LO, 1, 16'h1234),
    vw(P_FP, 0, 16'h0082),
    vr(3, P_LO, 1, 16'h1234),            // R3
    vr(4, P_HI, 0, 16'h0012),            // R4 high byte
    vr(4, P_LO, 0, 16'h0034),            // R4 low byte
    vr(4, P_HI, 1, 16'h1234),            // R4 word at high port
    vw(P_FP, 0, 16'h0002),
    vw(P_HI, 0, 16'h00AB),
    vw(P_FP, 0, 16'h0082),
    vr(7, P_LO, 1, 16'hAB34),            // R7 high lane
    vw(P_FP, 0, 16'h0002),
    vw(P_LO, 0, 16'h77CD),
    vw(P_FP, 0, 16'h0082),
    vr(7, P_LO, 1, 16'hABCD),            // R7 low lane
    vw(P_VP, 0, 16'h0004),
    vw(P_FP, 0, 16'h0002),
    vw(P_HI, 1, 16'h1111),
    vw(P_FP, 0, 16'h0082),
    vr(7, P_LO, 1, 16'h1111),            // R7 word write at high port
    vw(P_VP, 0, 16'h0023),
    vr(1, P_LO, 1, 16'hABCD),            // R1 masked voice, R3 isolation
    vw(P_VP, 0, 16'h001F),
    vw(P_FP, 0, 16'h000D),
    vw(P_LO, 1, 16'hBEEF),
    vw(P_FP, 0, 16'h008D),
    vr(3, P_LO, 1, 16'hBEEF),            // R3 last voice, last word
    vw(P_LO, 1, 16'h0000),
    vr(8, P_LO, 1, 16'hBEEF),            // R8 write with read code ignored
    vw(P_FP, 0, 16'h008F),
    vr(8, P_LO, 1, 16'hFFFF),            // R8 0x8F
    vr(8, P_HI, 0, 16'hFFFF),            // R8 byte size
    vw(P_FP, 0, 16'h000D),
    vr(8, P_LO, 1, 16'hFFFF),            // R8 write code read
    vw(P_FP, 0, 16'h000E),
    vw(P_LO, 1, 16'h0020),
    vw(P_FP, 0, 16'h008E),
    vr(5, P_LO, 1, 16'h0020),            // R5 count load
    vr(5, P_HI, 0, 16'h0020),            // R5 any port and size
    vw(P_FP, 0, 16'h004C),
    vw(P_LO, 1, 16'h0000),
    vw(P_FP, 0, 16'h008E),
    vr(5, P_LO, 1, 16'h00CD),            // R5 restore on run clear
    vw(P_FP, 0, 16'h000D),
    vw(P_LO, 1, 16'h1234),
    vw(P_FP, 0, 16'h008D),
    vr(6, P_LO, 1, 16'hBEEF)             // R6 gated write
  };

  task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] p, input logic w, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_port = p; host_word = w; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_read(input int req, input logic [1:0] p, input logic w, input logic [15:0] exp, input string what);
    @(negedge clk);
    host_rd = 1'b1; host_port = p; host_word = w;
    @(negedge clk);
    host_rd = 1'b0;
    check(9, {15'd0, host_rvalid}, 16'd1, "rvalid after read (R9)");
    check(req, host_rdata, exp, what);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(9, {15'd0, host_rvalid}, 16'd0, "rvalid in reset (R9)");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35])
        do_read(int'(VEC[i][39:36]), VEC[i][34:33], VEC[i][32], VEC[i][15:0], $sformatf("vector %0d", i));
      else
        do_write(VEC[i][34:33], VEC[i][32], VEC[i][31:16]);
    end

    // R9: valid drops in the idle cycle after a read
    @(negedge clk);
    check(9, {15'd0, host_rvalid}, 16'd0, "rvalid idle after read (R9)");

    // mid-run reset: pointers, run bit and count reinitialise, storage survives
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(9, {15'd0, host_rvalid}, 16'd0, "rvalid during reset (R9)");
    rst_n = 1'b1;
    do_read(1, P_VP, 0, 16'h0000, "voice pointer after reset (R1)");
    do_read(2, P_FP, 0, 16'h0000, "function pointer after reset (R2)");
    do_write(P_FP, 0, 16'h008E);
    do_read(5, P_LO, 1, 16'h00CD, "count after reset (R5)");
    do_write(P_VP, 0, 16'h001F);
    do_write(P_FP, 0, 16'h000D);
    do_write(P_LO, 1, 16'h5555);
    do_write(P_FP, 0, 16'h008D);
    do_read(6, P_LO, 1, 16'hBEEF, "write blocked after reset (R6)");
    do_write(P_FP, 0, 16'h004C);
    do_write(P_LO, 0, 16'h0001);
    do_write(P_FP, 0, 16'h000D);
    do_write(P_HI, 0, 16'h0042);
    do_write(P_FP, 0, 16'h008D);
    do_read(7, P_LO, 1, 16'h42EF, "high byte after run enabled (R7)");

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule